// File: doc/BRIEF.md
# Pulse-Position Preamble Detector with Adaptive Threshold

This block sits behind a magnitude computation in a 1090 MHz burst receiver and watches one unsigned magnitude sample per accepted input. A short sliding window feeds a matched filter whose taps are fixed by the four-pulse synchronisation pattern. A separate first-order filter on the same stream keeps a running estimate of the noise floor. A candidate window is accepted when its correlation beats a threshold scaled from that floor and is not exceeded by the next window. This lets one setting catch both weak and strong bursts among unrelated pulses in a busy band.

After acceptance the block counts further samples and fires a single-cycle strobe exactly when the first data bit's first sample has been taken in. A downstream bit slicer can then start its decisions from that sample. The strobe also arms a lockout that holds until the decoder drops its busy flag. The half-bit length in samples is a build-time parameter, and the template is derived from it.

Top module: `preamble_sync_detector`

## Requirements
- R1: While reset is high and in the cycle after it, dataStart is low; with all-zero input after reset dataStart never rises.
- R2: For an accepted window whose oldest sample has stream index k, dataStart is high for exactly one clock, in the cycle after the clock edge that accepts sample k + 16*SPH (the first data sample), where SPH is the samples per half-bit.
- R3: The correlation of a window of the last 10*SPH samples is the sum of the samples whose offset from the oldest one falls in half-bit slots 0, 2, 7 and 9 (each slot SPH samples long).
- R4: The correlation saturates at 2^CORR_W - 1 instead of wrapping.
- R5: The noise floor starts at 0 after reset and, for each accepted sample x, becomes floor + ((x - floor) >>> FLOOR_SHIFT), using signed arithmetic with the shift rounding toward minus infinity.
- R6: A window qualifies only if its correlation is strictly greater than max(floor, FLOOR_MIN) * thrGain, clamped to 2^CORR_W - 1, where floor is the estimate that includes the window's newest sample.
- R7: A window qualifies only if its correlation is greater than or equal to that of the window one sample later; on a flat peak the earlier window wins.
- R8: Once a window is accepted, no other window is accepted until its dataStart has fired and decBusy has then been seen low at a clock edge; the acceptance itself happens at the edge that takes in the sample two past the window's newest one.
- R9: Only clock edges with sampleValid high advance the window, the floor, the candidate and the data-start count; edges with sampleValid low change none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleMag | input | MAG_W | Unsigned magnitude sample |
| sampleValid | input | 1 | sampleMag is taken at this edge |
| thrGain | input | GAIN_W | Unsigned factor applied to the floor to form the threshold |
| decBusy | input | 1 | Decoder busy; keeps the detector locked after a strobe |
| dataStart | output | 1 | One-cycle strobe: the first data sample was just taken |

## Verification
A window ending at sample n has its correlation compared with its successor's after the edge that takes in sample n+1. It is accepted at the edge that takes in n+2. The strobe appears in the cycle after the edge that takes in sample n + 6*SPH + 1, which is sixteen half-bits after the window's oldest sample. The bench computes the correlation, floor and threshold for every stream index from the stated rules and walks the lockout with the same busy pattern it drives. It then queues the expected data-start sample indices. Its monitor samples two time units after each rising edge, so the index it holds is the sample taken at that edge and the strobe registered there. Sample gaps are inserted in one run, so counting is done in accepted samples rather than in clocks.

// File: rtl/preamble_sync_pkg.sv
`timescale 1ns/1ps
package preamble_sync_pkg;

  typedef enum logic [1:0] {
    SYNC_IDLE = 2'd0,
    SYNC_WAIT = 2'd1,
    SYNC_HOLD = 2'd2
  } syncState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;  // take the current sample
    logic armed;    // control is ready to accept a candidate
  } syncStrobe_t;

  // Half-bit slots 0, 2, 7, 9 of the ten-slot window carry a pulse
  function automatic logic isPulseSlot(input int offset, input int sph);
    int slot;
    slot = offset / sph;
    return (slot == 0) || (slot == 2) || (slot == 7) || (slot == 9);
  endfunction

endpackage

// File: rtl/preamble_sync_datapath.sv
`timescale 1ns/1ps
module preamble_sync_datapath
  import preamble_sync_pkg::*;
#(
  parameter int SPH         = 5,
  parameter int MAG_W       = 16,
  parameter int CORR_W      = 20,
  parameter int GAIN_W      = 8,
  parameter int FLOOR_SHIFT = 4,
  parameter int FLOOR_MIN   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAG_W-1:0]  sampleMag,
  input  logic [GAIN_W-1:0] thrGain,
  input  syncStrobe_t       strobe,
  output logic              candHit
);

  localparam int WIN    = 10 * SPH;
  localparam int TAPS   = 4 * SPH;
  localparam int SUM_W  = MAG_W + $clog2(TAPS) + 1;
  localparam int ACC_W  = (SUM_W > CORR_W) ? SUM_W : CORR_W;
  localparam int PROD_W = MAG_W + GAIN_W;
  localparam int PW     = (PROD_W > CORR_W) ? PROD_W : CORR_W;
  localparam logic [CORR_W-1:0] CORR_MAX = '1;

  logic [MAG_W-1:0]  window [WIN];
  logic [MAG_W-1:0]  floorEst;
  logic [ACC_W-1:0]  tapSum;
  logic [CORR_W-1:0] corrNow;
  logic [CORR_W-1:0] thrNow;
  logic [CORR_W-1:0] candCorr;
  logic [CORR_W-1:0] candThr;
  logic [MAG_W-1:0]  floorBase;
  logic [PW-1:0]     partial [GAIN_W];
  logic [PW-1:0]     prodSum;
  logic signed [MAG_W:0] floorDiff;
  logic signed [MAG_W:0] floorStep;
  logic signed [MAG_W:0] floorSum;

  // Sliding window, index 0 newest
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WIN; i++) window[i] <= '0;
    end else if (strobe.advance) begin
      window[0] <= sampleMag;
      for (int i = 1; i < WIN; i++) window[i] <= window[i-1];
    end
  end

  // Matched filter over the pulse slots, saturating
  always_comb begin
    tapSum = '0;
    for (int j = 0; j < WIN; j++) begin
      if (isPulseSlot(j, SPH)) tapSum = tapSum + ACC_W'(window[WIN-1-j]);
    end
    corrNow = (tapSum > ACC_W'(CORR_MAX)) ? CORR_MAX : tapSum[CORR_W-1:0];
  end

  // Noise floor: first-order recursive filter
  always_comb begin
    floorDiff = $signed({1'b0, sampleMag}) - $signed({1'b0, floorEst});
    floorStep = floorDiff >>> FLOOR_SHIFT;
    floorSum  = $signed({1'b0, floorEst}) + floorStep;
  end

  always_ff @(posedge clk) begin
    if (rst)                 floorEst <= '0;
    else if (strobe.advance) floorEst <= floorSum[MAG_W-1:0];
  end

  // Threshold: floor scaled by gain through shift-and-add
  assign floorBase = (floorEst < MAG_W'(FLOOR_MIN)) ? MAG_W'(FLOOR_MIN) : floorEst;

  for (genvar g = 0; g < GAIN_W; g++) begin : gTerm
    assign partial[g] = thrGain[g] ? (PW'(floorBase) << g) : '0;
  end

  always_comb begin
    prodSum = '0;
    for (int b = 0; b < GAIN_W; b++) prodSum = prodSum + partial[b];
    thrNow = (prodSum > PW'(CORR_MAX)) ? CORR_MAX : prodSum[CORR_W-1:0];
  end

  // Candidate stage: previous window against the current one
  always_ff @(posedge clk) begin
    if (rst) begin
      candCorr <= '0;
      candThr  <= '0;
    end else if (strobe.advance) begin
      candCorr <= corrNow;
      candThr  <= thrNow;
    end
  end

  assign candHit = strobe.armed && (candCorr > candThr) && (candCorr >= corrNow);

endmodule

// File: rtl/preamble_sync_control.sv
`timescale 1ns/1ps
module preamble_sync_control
  import preamble_sync_pkg::*;
#(
  parameter int SPH = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sampleValid,
  input  logic        decBusy,
  input  logic        candHit,
  output syncStrobe_t strobe,
  output logic        dataStart
);

  // Window end n, accepted at n+2, first data sample at n + 6*SPH + 1
  localparam int LEAD  = 6 * SPH - 1;
  localparam int CNT_W = $clog2(LEAD + 1);

  syncState_e       state;
  logic [CNT_W-1:0] leadCnt;

  assign strobe.advance = sampleValid;
  assign strobe.armed   = (state == SYNC_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SYNC_IDLE;
      leadCnt   <= '0;
      dataStart <= 1'b0;
    end else begin
      dataStart <= 1'b0;
      case (state)
        SYNC_IDLE: begin
          if (sampleValid && candHit) begin
            state   <= SYNC_WAIT;
            leadCnt <= CNT_W'(LEAD);
          end
        end
        SYNC_WAIT: begin
          if (sampleValid) begin
            if (leadCnt == CNT_W'(1)) begin
              dataStart <= 1'b1;
              state     <= SYNC_HOLD;
            end else begin
              leadCnt <= leadCnt - CNT_W'(1);
            end
          end
        end
        SYNC_HOLD: begin
          if (!decBusy) state <= SYNC_IDLE;
        end
        default: state <= SYNC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/preamble_sync_detector.sv
`timescale 1ns/1ps
module preamble_sync_detector
  import preamble_sync_pkg::*;
#(
  parameter int SPH         = 5,
  parameter int MAG_W       = 16,
  parameter int CORR_W      = 20,
  parameter int GAIN_W      = 8,
  parameter int FLOOR_SHIFT = 4,
  parameter int FLOOR_MIN   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAG_W-1:0]  sampleMag,
  input  logic              sampleValid,
  input  logic [GAIN_W-1:0] thrGain,
  input  logic              decBusy,
  output logic              dataStart
);

  syncStrobe_t strobe;
  logic        candHit;

  preamble_sync_datapath #(
    .SPH(SPH), .MAG_W(MAG_W), .CORR_W(CORR_W), .GAIN_W(GAIN_W),
    .FLOOR_SHIFT(FLOOR_SHIFT), .FLOOR_MIN(FLOOR_MIN)
  ) dp_i (
    .clk(clk), .rst(rst), .sampleMag(sampleMag), .thrGain(thrGain),
    .strobe(strobe), .candHit(candHit)
  );

  preamble_sync_control #(.SPH(SPH)) ctl_i (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .decBusy(decBusy),
    .candHit(candHit), .strobe(strobe), .dataStart(dataStart)
  );

endmodule

// File: rtl/preamble_sync_checker.sv
`timescale 1ns/1ps
module preamble_sync_checker #(
  parameter int SPH = 5
) (
  input logic clk,
  input logic rst,
  input logic sampleValid,
  input logic decBusy,
  input logic dataStart
);

  localparam int GAP_MIN = 6 * SPH;
  localparam int GAP_W   = $clog2(GAP_MIN + 1);

  logic             holdShadow;
  logic [GAP_W-1:0] sinceTrig;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdShadow <= 1'b0;
      sinceTrig  <= GAP_W'(GAP_MIN);
    end else begin
      if (dataStart)                    holdShadow <= decBusy;
      else if (holdShadow && !decBusy)  holdShadow <= 1'b0;
      if (dataStart)                    sinceTrig <= '0;
      else if (sampleValid && sinceTrig != GAP_W'(GAP_MIN))
                                        sinceTrig <= sinceTrig + GAP_W'(1);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !dataStart);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    dataStart |=> !dataStart);

  assert_after_sample_R9: assert property (@(posedge clk) disable iff (rst)
    dataStart |-> $past(sampleValid));

  assert_busy_lockout_R8: assert property (@(posedge clk) disable iff (rst)
    dataStart |-> !holdShadow);

  assert_min_spacing_R8: assert property (@(posedge clk) disable iff (rst)
    dataStart |-> (sinceTrig >= GAP_W'(GAP_MIN)));

endmodule

bind preamble_sync_detector preamble_sync_checker #(.SPH(SPH)) chk_i (
  .clk(clk), .rst(rst), .sampleValid(sampleValid),
  .decBusy(decBusy), .dataStart(dataStart)
);

// File: tb/preamble_sync_detector_tb_top.sv
`timescale 1ns/1ps
module preamble_sync_detector_tb_top;

  localparam int SPH         = 5;
  localparam int MAG_W       = 16;
  localparam int CORR_W      = 20;
  localparam int GAIN_W      = 8;
  localparam int FLOOR_SHIFT = 4;
  localparam int FLOOR_MIN   = 4;
  localparam int WIN         = 10 * SPH;
  localparam int CMAX        = (1 << CORR_W) - 1;
  localparam int MAXN        = 1300;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [MAG_W-1:0]  sampleMag = '0;
  logic              sampleValid = 1'b0;
  logic [GAIN_W-1:0] thrGain = '0;
  logic              decBusy = 1'b0;
  logic              dataStart;

  always #5 clk = ~clk;

  preamble_sync_detector #(
    .SPH(SPH), .MAG_W(MAG_W), .CORR_W(CORR_W), .GAIN_W(GAIN_W),
    .FLOOR_SHIFT(FLOOR_SHIFT), .FLOOR_MIN(FLOOR_MIN)
  ) dut_i (
    .clk(clk), .rst(rst), .sampleMag(sampleMag), .sampleValid(sampleValid),
    .thrGain(thrGain), .decBusy(decBusy), .dataStart(dataStart)
  );

  int    checks = 0;
  int    failures = 0;
  int    cycleCnt = 0;
  int    curIdx = -1;
  string curTag = "R1";
  int    expQ[$];
  int    samp[MAXN];
  int    busyArr[MAXN];
  int    corrArr[MAXN];
  int    thrArr[MAXN];
  int    lfsr = 16'hACE1;

  task automatic stepLfsr();
    if (lfsr & 1) lfsr = (lfsr >> 1) ^ 16'hB400;
    else          lfsr = lfsr >> 1;
  endtask

  task automatic fillNoise(input int n, input int base, input int mask);
    for (int i = 0; i < MAXN; i++) begin
      stepLfsr();
      samp[i] = (i < n) ? base + (lfsr & mask) : 0;
    end
  endtask

  task automatic addAt(input int idx, input int amp);
    if (idx < MAXN) samp[idx] = (samp[idx] + amp > 65535) ? 65535 : samp[idx] + amp;
  endtask

  // Preamble pulses in half-bit slots 0,2,7,9, then PPM data from slot 16
  task automatic addBurst(input int start, input int amp, input int wide, input int nbits);
    int slots[4] = '{0, 2, 7, 9};
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < SPH + wide; s++) addAt(start + slots[p] * SPH + s, amp);
    for (int b = 0; b < nbits; b++) begin
      stepLfsr();
      for (int s = 0; s < SPH; s++)
        addAt(start + (16 + 2 * b + ((lfsr & 1) ? 0 : 1)) * SPH + s, amp);
    end
  endtask

  function automatic int corrAt(input int i);
    int sum = 0;
    for (int j = 0; j < WIN; j++) begin
      int slot = j / SPH;
      int idx  = i - WIN + 1 + j;
      if ((slot == 0 || slot == 2 || slot == 7 || slot == 9) && idx >= 0) sum += samp[idx];
    end
    return (sum > CMAX) ? CMAX : sum;
  endfunction

  // Reference from the requirements, in the sample-index domain
  task automatic buildModel(input int n, input int gain, input int holdLen);
    int f = 0;
    int block = -1;
    for (int i = 0; i < MAXN; i++) busyArr[i] = 0;
    for (int i = 0; i < n; i++) begin
      int base;
      int t;
      f = f + ((samp[i] - f) >>> FLOOR_SHIFT);               // R5
      base = (f < FLOOR_MIN) ? FLOOR_MIN : f;
      t = base * gain;                                        // R6
      thrArr[i] = (t > CMAX) ? CMAX : t;
      corrArr[i] = corrAt(i);                                 // R3, R4
    end
    expQ.delete();
    for (int c = 0; c <= n - 3; c++) begin
      if (c + 2 > block && corrArr[c] > thrArr[c] && corrArr[c] >= corrArr[c+1]) begin // R7
        int d = c + 6 * SPH + 1;                              // R2
        if (d < n) expQ.push_back(d);
        for (int k = d + 1; k <= d + holdLen && k < n; k++) busyArr[k] = 1;
        block = d + holdLen + 1;                              // R8
      end
    end
  endtask

  task automatic runPhase(input string tag, input int n, input int gain,
                          input int holdLen, input bit gaps);
    buildModel(n, gain, holdLen);
    curTag = tag;
    @(negedge clk);
    rst = 1'b1; sampleValid = 1'b0; decBusy = 1'b0; thrGain = GAIN_W'(gain);
    curIdx = -1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (dataStart !== 1'b0) begin
      failures++;
      $display("FAIL R1 (%s): dataStart after reset = %b, expected 0", tag, dataStart);
    end
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 2)) begin
        sampleValid = 1'b0;
        @(negedge clk);
      end
      sampleMag = MAG_W'(samp[i]); sampleValid = 1'b1; decBusy = busyArr[i][0]; curIdx = i;
      @(negedge clk);
    end
    sampleValid = 1'b0; decBusy = 1'b0;
    repeat (8) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL %s: %0d expected dataStart strobes missing, expected 0 missing",
               tag, expQ.size());
    end
  endtask

  // Monitor: sample after the edge's updates have settled
  always @(posedge clk) begin
    #2;
    cycleCnt++;
    if (!rst && dataStart === 1'b1) begin : popBlk
      int e;
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL %s: dataStart after sample %0d, expected none", curTag, curIdx);
      end else begin
        e = expQ.pop_front();
        if (curIdx != e) begin
          failures++;
          $display("FAIL %s: dataStart after sample %0d, expected after sample %0d",
                   curTag, curIdx, e);
        end
      end
    end
    if (cycleCnt > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog: cycles %0d, expected at most 150000", cycleCnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: silent input after reset
    fillNoise(300, 0, 0);
    runPhase("R1 quiet", 300, 40, 0, 1'b0);
    // R2 R3: strong burst on low noise, timing of the strobe
    fillNoise(1000, 0, 7);
    addBurst(200, 3000, 0, 32);
    runPhase("R2 R3 strong burst", 1000, 40, 60, 1'b0);
    // R6: weak burst, modest gain -> found
    fillNoise(1000, 0, 7);
    addBurst(200, 30, 0, 32);
    runPhase("R6 weak burst low gain", 1000, 40, 60, 1'b0);
    // R6: same weak burst, high gain -> threshold too high
    fillNoise(1000, 0, 7);
    addBurst(200, 30, 0, 32);
    runPhase("R6 weak burst high gain", 1000, 200, 60, 1'b0);
    // R5: raised noise floor lifts the threshold
    fillNoise(1000, 100, 7);
    addBurst(300, 30, 0, 32);
    runPhase("R5 raised floor", 1000, 40, 60, 1'b0);
    // R4: full-scale pulses saturate the correlation
    fillNoise(1000, 0, 0);
    addBurst(200, 65535, 0, 32);
    runPhase("R4 saturation", 1000, 8, 60, 1'b0);
    // R8: second burst inside the busy lockout is ignored
    fillNoise(1200, 0, 7);
    addBurst(100, 3000, 0, 32);
    addBurst(260, 3000, 0, 8);
    addBurst(700, 3000, 0, 32);
    runPhase("R8 busy lockout", 1200, 40, 250, 1'b0);
    // R9: idle cycles between samples
    fillNoise(1100, 0, 7);
    addBurst(100, 3000, 0, 32);
    addBurst(600, 2000, 0, 32);
    runPhase("R9 sample gaps", 1100, 40, 0, 1'b1);
    // R7: widened pulses give a two-sample flat peak; earlier window wins
    fillNoise(1000, 0, 0);
    addBurst(200, 1000, 1, 32);
    runPhase("R7 flat peak", 1000, 8, 60, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule